// File: doc/BRIEF.md
# Audio Serial Clock Chain

This block derives the two timing clocks of an audio serial link, the bit clock and the left/right frame clock, from the master audio clock that runs the block. The bit clock is the master clock divided by 2 or by 4. The frame clock is the bit clock divided by 32, 64 or 128. Both outputs are registered and have a 50% duty cycle.

Software programs the block through a single-word write port. One enable bit starts and stops both clocks together. The two divisor fields only take effect at a frame boundary, so the link never sees a broken frame. A write that holds an unsupported frame-divisor code is dropped as a whole, and a sticky error flag records it.

Top module: `aud_sclk_gen`

## Requirements
- R1: While reset is held and after it is released, `bclk`, `lrclk` and `cfg_err` are 0 until a valid write enables the block.
- R2: While enabled, `bclk` has a period of 2 master-clock cycles when write bit 16 is 0 and 4 cycles when it is 1. It is high for exactly half of the period.
- R3: While enabled, `lrclk` has a period of 32, 64 or 128 `bclk` periods for codes 0, 1 and 2 in write bits 19:17. It is high for exactly half of the period.
- R4: While enabled, `lrclk` changes level only in the same master-clock cycle in which `bclk` falls.
- R5: Write bit 0 is the enable. When it is cleared, both outputs are low from the next master-clock cycle on. When it is set, both outputs are still low in the cycle after the write and start toggling afterwards.
- R6: A write whose bits 19:17 hold code 3 to 7 changes nothing: not the enable bit, and neither divisor.
- R7: `cfg_err` goes to 1 in the cycle after a write with an invalid frame code. After that it stays at 1 through later valid writes, until reset.
- R8: A divisor written while the clocks run is applied at the next falling edge of `lrclk`. A divisor written while the block is disabled is applied when it is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word: bit 0 enable, bit 16 bit-clock select, bits 19:17 frame code |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Left/right frame clock |
| cfg_err | output | 1 | Sticky flag: an invalid frame code was written |

## Verification
The assertions assume that `wr_data` only matters in cycles where `wr_en` is high. They also assume that reset is asserted for at least one clock edge before any check applies, because the run and boundary properties compare against the previous cycle. The stimulus changes every input on the falling edge of the master clock and holds each write strobe for exactly one cycle. It turns off its own frame/bit-edge monitor while it disables and re-enables the block. This keeps the observed behaviour inside the running window that the edge-alignment property covers.

// File: rtl/aud_sclk_pkg.sv
package aud_sclk_pkg;

  // Number of legal frame-divisor codes (0..2)
  localparam int LR_CODES    = 3;
  localparam int LR_CODE_W   = 3;
  localparam int LR_SEL_W    = 2;
  // Largest half period, in bit-clock periods and in master cycles
  localparam int LR_HALF_MAX = 64;
  localparam int BC_HALF_MAX = 2;
  localparam int LR_CNT_W    = $clog2(LR_HALF_MAX);
  localparam int BC_CNT_W    = (BC_HALF_MAX > 1) ? $clog2(BC_HALF_MAX) : 1;

  typedef struct packed {
    logic                en;
    logic                bsel;
    logic [LR_SEL_W-1:0] lsel;
  } sclk_cfg_t;

  typedef struct packed {
    logic                bsel;
    logic [LR_SEL_W-1:0] lsel;
  } sclk_div_t;

  // Half period of the bit clock, in master cycles, minus one
  function automatic logic [BC_CNT_W-1:0] bc_half_m1(input logic bsel);
    return bsel ? BC_CNT_W'(BC_HALF_MAX - 1) : '0;
  endfunction

  // Half period of the frame clock, in bit-clock periods, minus one
  function automatic logic [LR_CNT_W-1:0] lr_half_m1(input logic [LR_SEL_W-1:0] sel);
    return LR_CNT_W'((16 << sel) - 1);
  endfunction

endpackage

// File: rtl/aud_sclk_cfg.sv
module aud_sclk_cfg
  import aud_sclk_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int EN_POS   = 0,
  parameter int BSEL_POS = 16,
  parameter int LSEL_LSB = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output sclk_cfg_t         cfg,
  output logic              err
);

  logic [LR_CODE_W-1:0] code;
  logic                 bad;

  assign code = wr_data[LSEL_LSB +: LR_CODE_W];
  assign bad  = (code >= LR_CODE_W'(LR_CODES));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
      err <= 1'b0;
    end else if (wr_en) begin
      if (bad) begin
        err <= 1'b1;
      end else begin
        cfg.en   <= wr_data[EN_POS];
        cfg.bsel <= wr_data[BSEL_POS];
        cfg.lsel <= code[LR_SEL_W-1:0];
      end
    end
  end

  // R6: invalid frame code leaves the whole configuration untouched
  assert_bad_write_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bad) |=> $stable(cfg));

  // R7: invalid write raises the flag
  assert_err_raised_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bad) |=> err);

  // R7: flag is sticky
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

endmodule

// File: rtl/aud_sclk_bdiv.sv
module aud_sclk_bdiv
  import aud_sclk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic bsel,
  output logic bclk,
  output logic fall_evt
);

  logic [BC_CNT_W-1:0] cnt;
  logic                tick;

  assign tick     = run && (cnt == bc_half_m1(bsel));
  assign fall_evt = tick && bclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R5: stopped divider parks low
  assert_bclk_parked_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> !bclk);

endmodule

// File: rtl/aud_sclk_ldiv.sv
module aud_sclk_ldiv
  import aud_sclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                bfall,
  input  logic [LR_SEL_W-1:0] lsel,
  output logic                lrclk,
  output logic                frame_end
);

  logic [LR_CNT_W-1:0] cnt;
  logic                flip;

  assign flip      = run && bfall && (cnt == lr_half_m1(lsel));
  assign frame_end = flip && lrclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      lrclk <= 1'b0;
    end else if (flip) begin
      cnt   <= '0;
      lrclk <= ~lrclk;
    end else if (bfall) begin
      cnt   <= cnt + 1'b1;
    end
  end

  // R4: frame clock moves only on a bit-clock falling event
  assert_lr_on_bfall_R4: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && (lrclk != $past(lrclk))) |-> $past(bfall));

endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen
  import aud_sclk_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int EN_POS   = 0,
  parameter int BSEL_POS = 16,
  parameter int LSEL_LSB = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              bclk,
  output logic              lrclk,
  output logic              cfg_err
);

  sclk_cfg_t cfg;
  sclk_div_t act;
  logic      running;
  logic      run;
  logic      bfall;
  logic      frame_end;

  aud_sclk_cfg #(
    .DATA_W  (DATA_W),
    .EN_POS  (EN_POS),
    .BSEL_POS(BSEL_POS),
    .LSEL_LSB(LSEL_LSB)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .cfg    (cfg),
    .err    (cfg_err)
  );

  // One start cycle: the divisors are latched before the dividers run
  always_ff @(posedge clk) begin
    if (rst) running <= 1'b0;
    else     running <= cfg.en;
  end

  assign run = running && cfg.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= '0;
    end else if (!run || frame_end) begin
      act.bsel <= cfg.bsel;
      act.lsel <= cfg.lsel;
    end
  end

  aud_sclk_bdiv u_bdiv (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .bsel    (act.bsel),
    .bclk    (bclk),
    .fall_evt(bfall)
  );

  aud_sclk_ldiv u_ldiv (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .bfall    (bfall),
    .lsel     (act.lsel),
    .lrclk    (lrclk),
    .frame_end(frame_end)
  );

  // R5: cleared enable forces both outputs low one cycle later
  assert_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
    !cfg.en |=> (!bclk && !lrclk));

  // R8: running divisors switch only together with a frame-clock fall
  assert_switch_at_frame_R8: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && (act != $past(act))) |-> $fell(lrclk));

endmodule

// File: tb/aud_sclk_gen_bench.sv
`timescale 1ns/1ps
module aud_sclk_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        bclk, lrclk, cfg_err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  aud_sclk_gen u_aud_sclk_gen (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .bclk   (bclk),
    .lrclk  (lrclk),
    .cfg_err(cfg_err)
  );

  // Vector table: bit select, frame code, expected bclk period, expected lrclk period
  localparam int NV = 6;
  localparam int VB   [NV] = '{0, 0, 0, 1, 1, 1};
  localparam int VL   [NV] = '{0, 1, 2, 0, 1, 2};
  localparam int EXP_B[NV] = '{2, 2, 2, 4, 4, 4};
  localparam int EXP_L[NV] = '{64, 128, 256, 128, 256, 512};

  function automatic logic [31:0] mk(input bit en, input bit bs, input int code);
    logic [31:0] w = '0;
    w[0]     = en;
    w[16]    = bs;
    w[19:17] = code[2:0];
    return w;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic bit pick(input bit which);
    return which ? lrclk : bclk;
  endfunction

  // Measures one full high phase and the following low phase
  task automatic measure(input bit which, output int hi, output int lo);
    int guard = 0;
    hi = 0;
    lo = 0;
    while (pick(which) && guard < 2000) begin @(negedge clk); guard++; end
    while (!pick(which) && guard < 4000) begin @(negedge clk); guard++; end
    while (pick(which) && guard < 6000) begin @(negedge clk); hi++; guard++; end
    while (!pick(which) && guard < 8000) begin @(negedge clk); lo++; guard++; end
  endtask

  // R4 monitor: frame clock changes only where the bit clock falls
  bit mon_on = 1'b0;
  int mon_bad = 0;
  logic pb = 1'b0, pl = 1'b0;
  always @(negedge clk) begin
    if (mon_on && (lrclk != pl) && !(pb && !bclk)) mon_bad++;
    pb <= bclk;
    pl <= lrclk;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int hi, lo, h, l, busy;
    repeat (4) @(negedge clk);
    chk("R1", "bclk in reset", bclk, 0);
    chk("R1", "lrclk in reset", lrclk, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "bclk after reset", bclk, 0);
    chk("R1", "lrclk after reset", lrclk, 0);
    chk("R1", "cfg_err after reset", cfg_err, 0);

    // Table walk: R2, R3, R5 start
    for (int i = 0; i < NV; i++) begin
      mon_on = 1'b0;
      wr(mk(1'b0, 1'b0, 0));
      @(negedge clk);
      wr(mk(1'b1, VB[i][0], VL[i]));
      @(negedge clk);
      chk("R5", "bclk low at start", bclk, 0);
      chk("R5", "lrclk low at start", lrclk, 0);
      mon_on = 1'b1;
      measure(1'b0, hi, lo);
      chk("R2", "bclk high", hi, EXP_B[i] / 2);
      chk("R2", "bclk period", hi + lo, EXP_B[i]);
      measure(1'b1, hi, lo);
      chk("R3", "lrclk high", hi, EXP_L[i] / 2);
      chk("R3", "lrclk period", hi + lo, EXP_L[i]);
    end
    mon_on = 1'b0;
    chk("R4", "frame edges off bit-clock fall", mon_bad, 0);

    // R8: divisor change during a high phase waits for the frame boundary
    wr(mk(1'b0, 1'b0, 0));
    @(negedge clk);
    wr(mk(1'b1, 1'b0, 0));
    measure(1'b1, hi, lo);
    while (!lrclk) @(negedge clk);
    wr_en   = 1'b1;
    wr_data = mk(1'b1, 1'b0, 1);
    h = 1;
    @(negedge clk);
    wr_en = 1'b0;
    while (lrclk && h < 1000) begin h++; @(negedge clk); end
    l = 0;
    while (!lrclk && l < 1000) begin l++; @(negedge clk); end
    chk("R8", "high phase with old divisor", h, 32);
    chk("R8", "low phase with new divisor", l, 64);
    measure(1'b1, hi, lo);
    chk("R8", "period after switch", hi + lo, 128);

    // R6/R7: invalid frame code with enable cleared and bit select set
    wr(mk(1'b1, 1'b0, 0));
    measure(1'b1, hi, lo);
    wr(mk(1'b0, 1'b1, 5));
    chk("R7", "err after bad code", cfg_err, 1);
    measure(1'b0, hi, lo);
    chk("R6", "bclk period after bad write", hi + lo, 2);
    measure(1'b1, hi, lo);
    chk("R6", "lrclk period after bad write", hi + lo, 64);
    wr(mk(1'b1, 1'b0, 7));
    measure(1'b1, hi, lo);
    chk("R6", "lrclk period after code 7", hi + lo, 64);
    wr(mk(1'b1, 1'b0, 1));
    @(negedge clk);
    chk("R7", "err sticky after valid write", cfg_err, 1);

    // R5: disable parks both outputs low
    wr(mk(1'b0, 1'b0, 0));
    busy = 0;
    repeat (300) begin
      @(negedge clk);
      if (bclk || lrclk) busy++;
    end
    chk("R5", "toggles while disabled", busy, 0);

    // R7: only reset clears the flag
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7", "err cleared by reset", cfg_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule